// File: doc/BRIEF.md
# Highest-Priority Pending Interrupt Selector

This block picks the next interrupt source to service for one interrupt target context. It takes the per-source pending and claimed vectors, a small priority value per source and the context's priority threshold. It reports the identifier of the winning source, that source's priority, a valid flag and an interrupt-request line for the context. A source can win only if it is pending, not already claimed, and has a non-zero priority. Among the sources that can win, the highest priority wins. When priorities are equal, the lower identifier wins.

Identifier 0 is reserved to mean "nothing to service", so bit 0 of every input vector has no effect. The selection is a balanced binary reduction over the sources. A parameter places an output register after it, which adds one cycle of latency. The interrupt-request line is raised only when the winner's priority is strictly above the threshold.

Top module: `irq_prio_select`

## Requirements
- R1: When no source can win, `win_valid_o` is 0, `win_id_o` is 0, `win_prio_o` is 0 and `irq_o` is 0.
- R2: Among sources 1..NSRC that can win, the one with the largest priority is reported in `win_id_o`.
- R3: When several sources that can win share the largest priority, the one with the smallest identifier is reported.
- R4: A source whose bit in `claim_i` is 1 is never reported, even when its bit in `pend_i` is 1.
- R5: A source whose priority field is 0 is never reported.
- R6: Bit 0 of `pend_i` and `claim_i`, and priority field 0 (`prio_i[PW-1:0]`), have no effect on any output.
- R7: `irq_o` is 1 exactly when a winner exists and its priority is strictly greater than `thresh_i`. A winner whose priority equals the threshold gives `irq_o` = 0.
- R8: `win_prio_o` equals the priority field of the reported source. Source k's field is `prio_i[k*PW +: PW]`, which is 4 bits by default, so values run from 0 to 15.
- R9: With PIPE=1, every output reflects the inputs present at the previous rising clock edge, and all outputs are 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | NSRC+1 | Pending bit per source; bit k is source k |
| claim_i | input | NSRC+1 | Claimed bit per source; bit k is source k |
| prio_i | input | (NSRC+1)*PW | Priority fields; source k at bits k*PW +: PW |
| thresh_i | input | PW | Context priority threshold |
| win_id_o | output | $clog2(NSRC+1) | Winning source identifier, 0 when none |
| win_prio_o | output | PW | Priority of the winner, 0 when none |
| win_valid_o | output | 1 | A winner exists |
| irq_o | output | 1 | Interrupt request for the context |

## Verification
The bench forces many equal-priority ties, so that a tree which prefers the right-hand node shows up as a higher identifier being reported. It drives the reserved slot 0 as pending with the highest priority. A design that lets slot 0 through would report identifier 0 as valid. It sets the claimed bit on the top-priority source, where a design that forgets to mask it would keep picking that source. It also sets the threshold equal to the winner's priority, where a non-strict compare would raise the request line. The random patterns mix priority ranges and pending densities. These patterns also uncover zero-priority sources being treated as eligible, and outputs that appear a cycle early or late.

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
  parameter int NSRC = 31,
  parameter int PW   = 4,
  parameter bit PIPE = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC:0]          pend_i,
  input  logic [NSRC:0]          claim_i,
  input  logic [(NSRC+1)*PW-1:0] prio_i,
  input  logic [PW-1:0]          thresh_i,
  output logic [$clog2(NSRC+1)-1:0] win_id_o,
  output logic [PW-1:0]          win_prio_o,
  output logic                   win_valid_o,
  output logic                   irq_o
);
  localparam int IDW    = $clog2(NSRC+1);
  localparam int LEAVES = 1 << IDW;
  localparam int NODES  = 2 * LEAVES;

  logic [LEAVES-1:0] elig;
  logic [PW-1:0]     lp [LEAVES];
  logic [IDW-1:0]    li [LEAVES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i >= 1 && i <= NSRC) begin : g_real
      assign lp[i]   = prio_i[i*PW +: PW];
      assign elig[i] = pend_i[i] & ~claim_i[i] & (prio_i[i*PW +: PW] != '0);
    end else begin : g_pad
      assign lp[i]   = '0;
      assign elig[i] = 1'b0;
    end
    assign li[i] = IDW'(i);
  end

  logic           nv  [NODES];
  logic [PW-1:0]  npr [NODES];
  logic [IDW-1:0] nid [NODES];
  logic           take_r;

  always_comb begin
    take_r = 1'b0;
    nv[0]  = 1'b0;
    npr[0] = '0;
    nid[0] = '0;
    for (int i = 0; i < LEAVES; i++) begin
      nv[LEAVES+i]  = elig[i];
      npr[LEAVES+i] = lp[i];
      nid[LEAVES+i] = li[i];
    end
    for (int n = LEAVES-1; n >= 1; n--) begin
      take_r = nv[2*n+1] && (!nv[2*n] || (npr[2*n+1] > npr[2*n]));
      nv[n]  = nv[2*n] | nv[2*n+1];
      npr[n] = take_r ? npr[2*n+1] : npr[2*n];
      nid[n] = take_r ? nid[2*n+1] : nid[2*n];
    end
  end

  logic           sel_valid;
  logic [IDW-1:0] sel_id;
  logic [PW-1:0]  sel_prio;
  logic           sel_irq;

  assign sel_valid = nv[1];
  assign sel_id    = nv[1] ? nid[1] : '0;
  assign sel_prio  = nv[1] ? npr[1] : '0;
  assign sel_irq   = sel_valid && (sel_prio > thresh_i);

  if (PIPE) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_valid_o <= 1'b0;
        win_id_o    <= '0;
        win_prio_o  <= '0;
        irq_o       <= 1'b0;
      end else begin
        win_valid_o <= sel_valid;
        win_id_o    <= sel_id;
        win_prio_o  <= sel_prio;
        irq_o       <= sel_irq;
      end
    end
  end else begin : g_comb
    assign win_valid_o = sel_valid;
    assign win_id_o    = sel_id;
    assign win_prio_o  = sel_prio;
    assign irq_o       = sel_irq;
  end

  // R1
  none_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (elig == '0));

  // R4
  winner_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (pend_i[sel_id] && !claim_i[sel_id]));

  // R6
  no_zero_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_id != '0 && int'(sel_id) <= NSRC));

  // R8
  prio_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_prio == prio_i[sel_id*PW +: PW] && sel_prio != '0));

  // R7
  irq_has_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> win_valid_o);
endmodule

// File: tb/tb_irq_prio_select.sv
module tb_irq_prio_select;
  localparam int CLK_P = 10;
  localparam int NSRC  = 31;
  localparam int PW    = 4;
  localparam int IDW   = $clog2(NSRC+1);

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [NSRC:0]          pend = '0;
  logic [NSRC:0]          claim = '0;
  logic [(NSRC+1)*PW-1:0] prio = '0;
  logic [PW-1:0]          thr = '0;
  logic [IDW-1:0]         win_id;
  logic [PW-1:0]          win_prio;
  logic                   win_valid;
  logic                   irq;

  int checks = 0;
  int errors = 0;
  int e_id, e_pr, e_v, e_irq;
  int p_id, p_pr, p_v, p_irq;

  irq_prio_select #(.NSRC(NSRC), .PW(PW), .PIPE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .claim_i(claim), .prio_i(prio),
    .thresh_i(thr), .win_id_o(win_id), .win_prio_o(win_prio),
    .win_valid_o(win_valid), .irq_o(irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ref_model();
    int bp;
    e_id = 0;
    bp = 0;
    for (int k = 1; k <= NSRC; k++) begin
      int pk;
      pk = int'(prio[k*PW +: PW]);
      if (pend[k] && !claim[k] && pk != 0 && (e_id == 0 || pk > bp)) begin
        e_id = k;
        bp = pk;
      end
    end
    e_pr  = bp;
    e_v   = (e_id != 0) ? 1 : 0;
    e_irq = (e_id != 0 && bp > int'(thr)) ? 1 : 0;
  endtask

  task automatic set_prio(input int k, input int v);
    prio[k*PW +: PW] = PW'(v);
  endtask

  task automatic step(input string req);
    p_id = e_id; p_pr = e_pr; p_v = e_v; p_irq = e_irq;
    ref_model();
    #1;
    // R9: outputs hold until the next rising edge
    chk("R9 latency id", int'(win_id), p_id);
    @(posedge clk);
    #1;
    chk({req, " id"}, int'(win_id), e_id);
    chk({req, " valid"}, int'(win_valid), e_v);
    chk({req, " prio R8"}, int'(win_prio), e_pr);
    chk({req, " irq R7"}, int'(irq), e_irq);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P*200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    e_id = 0; e_pr = 0; e_v = 0; e_irq = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset id", int'(win_id), 0);
    chk("R9 reset valid", int'(win_valid), 0);
    chk("R9 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: nothing pending
    pend = '0; claim = '0; prio = '0; thr = '0;
    step("R1 empty");

    // R6: slot 0 pending at top priority only
    pend[0] = 1'b1; set_prio(0, 15);
    step("R6 slot0");

    // R5: pending sources with priority 0
    pend = '1; prio = '0;
    step("R5 zero prio");

    // R3: all equal priority, lowest id wins
    for (int k = 0; k <= NSRC; k++) set_prio(k, 7);
    pend = '1;
    step("R3 tie all");
    pend[1] = 1'b0; pend[2] = 1'b0;
    step("R3 tie from 3");

    // R2: single higher priority at top id
    set_prio(NSRC, 9);
    step("R2 top wins");

    // R4: claimed top is skipped
    claim[NSRC] = 1'b1;
    step("R4 claimed skip");
    claim = '1;
    step("R4 all claimed");

    // R7: threshold equal and one below
    claim = '0; thr = 4'd9;
    step("R7 thr equal");
    thr = 4'd8;
    step("R7 thr below");
    thr = 4'd15;
    step("R7 thr max");

    // R2 R3 R4 R5: random patterns
    for (int it = 0; it < 3000; it++) begin
      int mode;
      mode = it % 4;
      for (int k = 0; k <= NSRC; k++) begin
        pend[k]  = (mode == 0) ? ($urandom_range(0, 7) == 0) : ($urandom_range(0, 1) == 1);
        claim[k] = ($urandom_range(0, 3) == 0);
        set_prio(k, (mode == 1) ? int'($urandom_range(0, 2)) : int'($urandom_range(0, 15)));
      end
      thr = PW'($urandom_range(0, 15));
      step("R2 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule